// File: doc/BRIEF.md
# Clocked Bus Read Sequencer with Wait States

This block is a bus master that turns a local read request into a memory read cycle made of fixed clock states. In the first state it drives the requested address. In the second state it raises the read strobe while the address stays on the bus. Read data is normally captured on the clock edge that ends the second state.

A memory that needs more time pulls the ready line low as soon as it sees the read strobe. Each clock period with ready low adds one wait state. During a wait state the address and the strobe are held unchanged. Data is captured on the first edge at which ready is sampled high. In the state that follows capture, the strobe drops, the address bus is released, and a one-cycle done pulse comes out with the captured word.

A parameter bounds the number of wait states. A memory that stays not-ready beyond that bound ends the cycle with a timeout pulse instead of a done pulse. Requests are taken only while the block is idle, and a busy output tells the requester when it must wait.

Top module: `sbus_read_ctrl`

## Requirements
- R1: When `req_i` is high at a clock edge while idle, the following cycle (first state) has `bus_addr_oe_o`=1, `bus_addr_o` equal to the sampled `addr_i`, `bus_rd_o`=0 and `busy_o`=1.
- R2: The cycle after the first state (second state) has `bus_rd_o`=1 and `bus_addr_o` unchanged.
- R3: If `bus_ready_i` is high at the edge that ends the second state, `bus_data_i` is captured at that edge, and the next cycle shows `done_o`=1 with `data_o` equal to the captured word.
- R4: If `bus_ready_i` is low at the edge that ends the second state or a wait state (and the wait limit is not reached), one wait state follows in which `bus_rd_o`=1 and `bus_addr_o` is unchanged.
- R5: Data is captured on the first edge at which `bus_ready_i` is high. With N wait states (N ≤ MAX_WAIT), `done_o` rises N+3 cycles after the accepting edge.
- R6: In the cycle after capture or timeout, `bus_rd_o`=0, `bus_addr_oe_o`=0 and `bus_addr_o`=0.
- R7: `done_o` lasts exactly one cycle, and `data_o` keeps its value until the next successful capture.
- R8: If ready is still low at the edge ending the MAX_WAIT-th wait state, the next cycle shows `timeout_o`=1 for one cycle with `done_o`=0, and `data_o` is left unchanged.
- R9: `busy_o` is high from the first state through the done/timeout cycle. A request present in any of those cycles is ignored and does not start a cycle.
- R10: After reset, `busy_o`, `bus_rd_o`, `bus_addr_oe_o`, `done_o` and `timeout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, sampled while idle |
| addr_i | input | ADDR_W | Address of the requested read |
| busy_o | output | 1 | A cycle is in progress |
| bus_addr_o | output | ADDR_W | Address bus, 0 when released |
| bus_addr_oe_o | output | 1 | Address bus driven |
| bus_rd_o | output | 1 | Read strobe |
| bus_data_i | input | DATA_W | Read data from memory |
| bus_ready_i | input | 1 | Memory ready, low inserts wait states |
| data_o | output | DATA_W | Last captured word |
| done_o | output | 1 | One-cycle pulse on a completed read |
| timeout_o | output | 1 | One-cycle pulse when the wait limit is exceeded |

## Verification
The bench builds the block with ADDR_W=12, DATA_W=8 and MAX_WAIT=3. A limit this small puts the exact-limit case (three wait states, still successful) and the over-limit timeout within a few cycles of each other. The bench's memory model returns a garbage word while it is not ready. Any capture on the wrong edge therefore shows up as a data mismatch, and the wait count of each read sets the exact done cycle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STROBE,
    ST_WAIT,
    ST_END
  } tstate_e;
endpackage

// File: rtl/sbus_tseq.sv
module sbus_tseq
  import sbus_pkg::*;
#(
  parameter int MAX_WAIT = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    ready_i,
  output tstate_e state_o,
  output logic    accept_o,
  output logic    capture_o,
  output logic    expired_o
);
  localparam int WCW = $clog2(MAX_WAIT + 1);

  tstate_e       state_q, state_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic          to_q, to_d;
  logic          at_limit;

  assign at_limit = (wcnt_q == WCW'(MAX_WAIT));

  always_comb begin
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    to_d      = to_q;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        to_d     = 1'b0;
        state_d  = ST_ADDR;
      end
      ST_ADDR: state_d = ST_STROBE;
      ST_STROBE: begin
        if (ready_i) begin
          capture_o = 1'b1;
          state_d   = ST_END;
        end else begin
          wcnt_d  = WCW'(1);
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (ready_i) begin
          capture_o = 1'b1;
          state_d   = ST_END;
        end else if (at_limit) begin
          to_d    = 1'b1;
          state_d = ST_END;
        end else begin
          wcnt_d = wcnt_q + WCW'(1);
        end
      end
      ST_END: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      to_q    <= to_d;
    end
  end

  assign state_o   = state_q;
  assign expired_o = to_q;

  // R8
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !ready_i && at_limit) |=> (state_q == ST_END && to_q));
endmodule

// File: rtl/sbus_hold.sv
module sbus_hold #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
    end else begin
      if (load_i)    addr_o <= addr_i;
      if (capture_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/sbus_read_ctrl.sv
module sbus_read_ctrl
  import sbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int MAX_WAIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_addr_oe_o,
  output logic              bus_rd_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              timeout_o
);
  tstate_e           state;
  logic              accept, capture, expired;
  logic [ADDR_W-1:0] addr_q;

  sbus_tseq #(.MAX_WAIT(MAX_WAIT)) u_tseq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ready_i   (bus_ready_i),
    .state_o   (state),
    .accept_o  (accept),
    .capture_o (capture),
    .expired_o (expired)
  );

  sbus_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .addr_i    (addr_i),
    .capture_i (capture),
    .data_i    (bus_data_i),
    .addr_o    (addr_q),
    .data_o    (data_o)
  );

  assign bus_addr_oe_o = (state == ST_ADDR) || (state == ST_STROBE) || (state == ST_WAIT);
  assign bus_rd_o      = (state == ST_STROBE) || (state == ST_WAIT);
  assign bus_addr_o    = bus_addr_oe_o ? addr_q : '0;
  assign busy_o        = (state != ST_IDLE);
  assign done_o        = (state == ST_END) && !expired;
  assign timeout_o     = (state == ST_END) && expired;

  // R1
  addr_before_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_addr_oe_o) |-> !bus_rd_o);
  // R2
  rd_has_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |-> bus_addr_oe_o);
  // R4
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && !bus_ready_i) |=> (timeout_o || (bus_rd_o && $stable(bus_addr_o))));
  // R3
  ready_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && bus_ready_i) |=> (done_o && !bus_rd_o && data_o == $past(bus_data_i)));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  timeout_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!done_o && $stable(data_o)));
endmodule

// File: tb/sbus_read_ctrl_bench.sv
module sbus_read_ctrl_bench;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int MW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          busy, oe, rd, done, tmo, ready;
  logic [AW-1:0] baddr;
  logic [DW-1:0] bdata, dout;

  int checks = 0;
  int failures = 0;
  int mem_waits = 0;
  int rd_cnt = 0;

  always #10 clk = ~clk;

  sbus_read_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_WAIT(MW)) u_sbus_read_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .busy_o(busy),
    .bus_addr_o(baddr), .bus_addr_oe_o(oe), .bus_rd_o(rd), .bus_data_i(bdata),
    .bus_ready_i(ready), .data_o(dout), .done_o(done), .timeout_o(tmo)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) rd_cnt <= rd ? rd_cnt + 1 : 0;
  assign ready = !rd || (rd_cnt >= mem_waits);
  assign bdata = (rd && ready) ? mem_word(baddr) : 8'hEE;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !rd && !oe && !done && !tmo, "R10 reset outputs", {busy, rd, oe, done, tmo}, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input int waits, input bit keep_req);
    int nw;
    bit exp_to;
    logic [DW-1:0] prev;
    exp_to = (waits > MW);
    nw = exp_to ? MW : waits;
    prev = dout;
    mem_waits = waits;
    @(negedge clk);
    req = 1'b1;
    addr = a;
    @(negedge clk);
    if (keep_req) addr = ~a; else req = 1'b0;
    chk(oe && baddr == a && !rd && busy, "R1 first state", baddr, a);
    @(negedge clk);
    chk(rd && baddr == a, "R2 strobe state", {rd, baddr}, {1'b1, a});
    for (int i = 1; i <= nw; i++) begin
      @(negedge clk);
      chk(rd && baddr == a && !done && !tmo, "R4 wait state held", {rd, baddr}, {1'b1, a});
    end
    @(negedge clk);
    if (exp_to) begin
      chk(tmo && !done, "R8 timeout pulse", {tmo, done}, 2'b10);
      chk(dout == prev, "R8 data unchanged", dout, prev);
    end else begin
      chk(done && !tmo, "R5 done after waits", {done, tmo}, 2'b10);
      chk(dout == mem_word(a), "R3 captured data", dout, mem_word(a));
    end
    chk(!rd && !oe && baddr == '0 && busy, "R6 bus released", {rd, oe, baddr}, 0);
    req = 1'b0;
    prev = dout;
    @(negedge clk);
    chk(!done && !tmo && !busy, "R7 single pulse, idle", {done, tmo, busy}, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!oe && !busy && dout == prev, "R9 no extra cycle, R7 data kept", {oe, busy}, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(12'h3C1, 0, 1'b0);
    t_read(12'hA52, 1, 1'b0);
    t_read(12'h7F0, 2, 1'b0);
    t_read(12'h0D9, MW, 1'b0);
    t_read(12'h444, MW + 2, 1'b0);
    t_read(12'hB17, 1, 1'b1);
    t_read(12'hFFF, 0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule